// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block collects interrupt requests for a small 8-bit processor core and turns them into one vectored service request at a time. It has four request sources: timer 0 overflow, timer 1 overflow, a combined USB event source, and a rising edge on an external pin. Each source latches a request flag. An 8-bit control word holds these flags, a master enable and one enable per source, and the core reads and writes it as a normal register. A second register, the event status word, records which USB condition occurred (suspend, resume, access to one of the endpoint FIFOs). It also records whether the external pin fired. The bits of the event status word stay set until firmware writes them to zero.

The external pin and the USB source share vector 04H. Firmware tells them apart through the status word. Timer 0 vectors to 08H and timer 1 to 0CH. The core holds the controller off while its return stack is full. When the core accepts an offered vector, it pulses the acknowledge input. The controller then clears the master enable and the serviced flag, so a second interrupt can only follow once firmware sets the master enable again. A wake-up output reports that a source other than the external pin has an enabled flag pending.

The decision logic is a two-state machine. In IDLE it watches for a grantable request. The transition "grant" (IDLE to OFFER) latches the winning source. The state OFFER holds `irq_take` and the vector steady. The transition "ack" (OFFER to IDLE) happens on `irq_ack` and performs the clears.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the control word, the status word, `irq_take` and `wake` are all zero.
- R2: A control write stores bits 0 to 6 as written. Bit 0 is the master enable, bit 1 the USB enable, bit 2 the timer 0 enable, bit 3 the timer 1 enable, bit 4 the USB flag, bit 5 the timer 0 flag and bit 6 the timer 1 flag. Bit 7 always reads 0.
- R3: A one-cycle pulse on `tmr0_ovf` sets bit 5 and a pulse on `tmr1_ovf` sets bit 6. Any USB event pulse (FIFO access, suspend, resume, bus reset) sets bit 4. The flags are set whatever the enables hold, and they are visible the cycle after the pulse.
- R4: In the status word, suspend sets bit 0, an external rising edge sets bit 1, resume sets bit 3, and an access to FIFO k sets bit 4+k. Bit 2 reads 0. A bus reset sets no status bit. Status bits hold until firmware writes them to zero.
- R5: A request is eligible when its flag and its enable are both set. For the external pin, eligibility needs a latched rising edge and `ext_irq_en`. While in IDLE with the master enable set, `stack_full` low and some request eligible, `irq_take` rises one cycle later.
- R6: The vector is 04H for USB or external, 08H for timer 0 and 0CH for timer 1. When several requests are eligible, 04H beats 08H, which beats 0CH.
- R7: While `stack_full` is high no new offer is made. The pending request is offered in the cycle after `stack_full` falls.
- R8: Once made, an offer holds `irq_take` and `irq_vec` steady until `irq_ack`. In the cycle after the acknowledge, `irq_take` is low, the master enable is 0 and the serviced flag is 0, while the other flags and enables are unchanged. Servicing 04H also drops the latched external edge.
- R9: After an acknowledge, no further offer is made while the master enable stays 0, even with requests eligible.
- R10: A hardware set of a flag or status bit wins over a firmware write of 0 to it in the same cycle.
- R11: `wake` is high exactly when an enabled USB, timer 0 or timer 1 flag is set. The external pin never drives it.
- R12: Only a rising edge of `ext_pin` records an external request. A pin held high does not request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read value |
| stat_wr | input | 1 | Write strobe for the event status word |
| stat_wdata | input | STAT_W | Event status write data |
| stat_rdata | output | STAT_W | Event status read value |
| usb_fifo_acc | input | NUM_FIFO | One-cycle pulse per endpoint FIFO accessed by the host |
| usb_suspend | input | 1 | Suspend event pulse |
| usb_resume | input | 1 | Resume event pulse |
| usb_bus_rst | input | 1 | Bus reset event pulse |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| ext_pin | input | 1 | External interrupt pin, synchronous to clk |
| ext_irq_en | input | 1 | Enable for the external source |
| stack_full | input | 1 | Core return stack is full |
| irq_take | output | 1 | Interrupt offered to the core |
| irq_vec | output | VEC_W | Vector address of the offer |
| irq_ack | input | 1 | Core accepts the offer |
| wake | output | 1 | Wake-up request |

## Verification
Suppose a flag register fails to set or to clear. The read port shows it in the cycle after the event or the acknowledge. The `wake` level shows it at the same time, and a missing or extra offer follows one cycle later. If the latched source is wrong, `irq_vec` reads a different address from the first cycle of `irq_take`. If the state machine is stuck, `irq_take` either stays low past the cycle after the grant condition or stays high past the cycle after an acknowledge. The bench sweeps every combination of enables and flags, so each priority slot and each clear is observed within two cycles of being created.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_OFFER
    } vic_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_USBX,
        SRC_TMR0,
        SRC_TMR1
    } vic_src_e;

    localparam int CW_EMI = 0;
    localparam int CW_EUSB = 1;
    localparam int CW_ET0 = 2;
    localparam int CW_ET1 = 3;
    localparam int CW_FUSB = 4;
    localparam int CW_FT0 = 5;
    localparam int CW_FT1 = 6;
    localparam int CW_RSV = 7;

    localparam int SW_SUSP = 0;
    localparam int SW_EXTO = 1;
    localparam int SW_RSV = 2;
    localparam int SW_RESM = 3;
    localparam int SW_FIFO = 4;

    localparam int NUM_SRC = 3;

    function automatic logic [7:0] vec_of(input vic_src_e s);
        case (s)
            SRC_USBX: vec_of = 8'h04;
            SRC_TMR0: vec_of = 8'h08;
            SRC_TMR1: vec_of = 8'h0C;
            default:  vec_of = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/vic_flags.sv
module vic_flags
    import vic_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    localparam int STAT_W = SW_FIFO + NUM_FIFO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic [NUM_FIFO-1:0] usb_fifo_acc,
    input  logic              usb_suspend,
    input  logic              usb_resume,
    input  logic              usb_bus_rst,
    input  logic              tmr0_ovf,
    input  logic              tmr1_ovf,
    input  logic              ext_pin,
    input  logic              svc_clr,
    input  vic_src_e          svc_src,
    output logic [7:0]        ctrl_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              ext_pend_q
);

    logic [7:0]        ctrl_d;
    logic [STAT_W-1:0] stat_d;
    logic              ext_pend_d;
    logic              pin_q;
    logic              ext_rise;
    logic              usb_any;

    assign ext_rise = ext_pin & ~pin_q;
    assign usb_any  = (|usb_fifo_acc) | usb_suspend | usb_resume | usb_bus_rst;

    // control word: firmware write, then service clear, then hardware set
    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr) begin
            ctrl_d = reg_wdata;
        end
        if (svc_clr) begin
            ctrl_d[CW_EMI] = 1'b0;
            case (svc_src)
                SRC_USBX: ctrl_d[CW_FUSB] = 1'b0;
                SRC_TMR0: ctrl_d[CW_FT0]  = 1'b0;
                SRC_TMR1: ctrl_d[CW_FT1]  = 1'b0;
                default:  ;
            endcase
        end
        if (usb_any) begin
            ctrl_d[CW_FUSB] = 1'b1;
        end
        if (tmr0_ovf) begin
            ctrl_d[CW_FT0] = 1'b1;
        end
        if (tmr1_ovf) begin
            ctrl_d[CW_FT1] = 1'b1;
        end
        ctrl_d[CW_RSV] = 1'b0;
    end

    // event status word
    always_comb begin
        stat_d = stat_q;
        if (stat_wr) begin
            stat_d = stat_wdata;
        end
        if (usb_suspend) begin
            stat_d[SW_SUSP] = 1'b1;
        end
        if (usb_resume) begin
            stat_d[SW_RESM] = 1'b1;
        end
        if (ext_rise) begin
            stat_d[SW_EXTO] = 1'b1;
        end
        for (int k = 0; k < NUM_FIFO; k++) begin
            if (usb_fifo_acc[k]) begin
                stat_d[SW_FIFO + k] = 1'b1;
            end
        end
        stat_d[SW_RSV] = 1'b0;
    end

    always_comb begin
        ext_pend_d = ext_pend_q;
        if (svc_clr && svc_src == SRC_USBX) begin
            ext_pend_d = 1'b0;
        end
        if (ext_rise) begin
            ext_pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            stat_q     <= '0;
            ext_pend_q <= 1'b0;
            pin_q      <= 1'b0;
        end else begin
            ctrl_q     <= ctrl_d;
            stat_q     <= stat_d;
            ext_pend_q <= ext_pend_d;
            pin_q      <= ext_pin;
        end
    end

endmodule

// File: rtl/vic_arb.sv
module vic_arb
    import vic_pkg::*;
(
    input  logic [7:0] ctrl_q,
    input  logic       ext_pend_q,
    input  logic       ext_irq_en,
    output logic       any_elig,
    output vic_src_e   win_src,
    output logic       wake
);

    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] wake_src;
    vic_src_e           src_tab [NUM_SRC];

    assign src_tab[0] = SRC_USBX;
    assign src_tab[1] = SRC_TMR0;
    assign src_tab[2] = SRC_TMR1;

    // per-source request terms, one slot per vector
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            assign wake_src[g] = ctrl_q[CW_FUSB + g] & ctrl_q[CW_EUSB + g];
            if (g == 0) begin : g_shared
                assign elig[g] = wake_src[g] | (ext_pend_q & ext_irq_en);
            end else begin : g_plain
                assign elig[g] = wake_src[g];
            end
        end
    endgenerate

    // lowest slot index wins
    always_comb begin
        win_src = SRC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_src = src_tab[i];
            end
        end
    end

    assign any_elig = |elig;
    assign wake     = |wake_src;

endmodule

// File: rtl/vic_fsm.sv
module vic_fsm
    import vic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     emi,
    input  logic     stack_full,
    input  logic     any_elig,
    input  vic_src_e win_src,
    input  logic     irq_ack,
    output logic     irq_take,
    output logic     svc_clr,
    output vic_src_e svc_src,
    output logic [7:0] vec8
);

    vic_state_e state_q;
    vic_state_e state_d;
    vic_src_e   src_q;
    logic       grant;

    assign grant = emi & ~stack_full & any_elig;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (grant)   state_d = ST_OFFER;
            ST_OFFER: if (irq_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and latched source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && grant) begin
                src_q <= win_src;
            end
        end
    end

    // outputs
    always_comb begin
        irq_take = 1'b0;
        svc_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_OFFER: begin
                irq_take = 1'b1;
                svc_clr  = irq_ack;
            end
            default:  ;
        endcase
    end

    assign svc_src = src_q;
    assign vec8    = irq_take ? vec_of(src_q) : 8'h00;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int VEC_W = 8,
    localparam int STAT_W = SW_FIFO + NUM_FIFO
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                stat_wr,
    input  logic [STAT_W-1:0]   stat_wdata,
    output logic [STAT_W-1:0]   stat_rdata,
    input  logic [NUM_FIFO-1:0] usb_fifo_acc,
    input  logic                usb_suspend,
    input  logic                usb_resume,
    input  logic                usb_bus_rst,
    input  logic                tmr0_ovf,
    input  logic                tmr1_ovf,
    input  logic                ext_pin,
    input  logic                ext_irq_en,
    input  logic                stack_full,
    output logic                irq_take,
    output logic [VEC_W-1:0]    irq_vec,
    input  logic                irq_ack,
    output logic                wake
);

    logic [7:0]  ctrl_q;
    logic        ext_pend_q;
    logic        any_elig;
    logic        svc_clr;
    vic_src_e    win_src;
    vic_src_e    svc_src;
    logic [7:0]  vec8;

    vic_flags #(.NUM_FIFO(NUM_FIFO)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .stat_wr     (stat_wr),
        .stat_wdata  (stat_wdata),
        .usb_fifo_acc(usb_fifo_acc),
        .usb_suspend (usb_suspend),
        .usb_resume  (usb_resume),
        .usb_bus_rst (usb_bus_rst),
        .tmr0_ovf    (tmr0_ovf),
        .tmr1_ovf    (tmr1_ovf),
        .ext_pin     (ext_pin),
        .svc_clr     (svc_clr),
        .svc_src     (svc_src),
        .ctrl_q      (ctrl_q),
        .stat_q      (stat_rdata),
        .ext_pend_q  (ext_pend_q)
    );

    vic_arb u_arb (
        .ctrl_q    (ctrl_q),
        .ext_pend_q(ext_pend_q),
        .ext_irq_en(ext_irq_en),
        .any_elig  (any_elig),
        .win_src   (win_src),
        .wake      (wake)
    );

    vic_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .emi       (ctrl_q[CW_EMI]),
        .stack_full(stack_full),
        .any_elig  (any_elig),
        .win_src   (win_src),
        .irq_ack   (irq_ack),
        .irq_take  (irq_take),
        .svc_clr   (svc_clr),
        .svc_src   (svc_src),
        .vec8      (vec8)
    );

    assign reg_rdata = ctrl_q;
    assign irq_vec   = VEC_W'(vec8);

endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       reg_rdata,
    input logic             stack_full,
    input logic             tmr0_ovf,
    input logic             irq_take,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack
);

    // R2
    rsv_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] == 1'b0);

    // R5 R7
    take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_take) |-> ($past(reg_rdata[0]) && !$past(stack_full)));

    // R6
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_vec == VEC_W'(4) || irq_vec == VEC_W'(8) || irq_vec == VEC_W'(12)));

    // R8
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !irq_ack) |=> (irq_take && $stable(irq_vec)));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_ack) |=> (!irq_take && !reg_rdata[0]));

    // R10
    t0_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr0_ovf |=> reg_rdata[5]);

endmodule

bind vec_irq_ctrl vic_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .stack_full(stack_full),
    .tmr0_ovf  (tmr0_ovf),
    .irq_take  (irq_take),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack)
);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;

    localparam int NF = 4;
    localparam int SW = 4 + NF;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          stat_wr = 1'b0;
    logic [SW-1:0] stat_wdata = '0;
    logic [SW-1:0] stat_rdata;
    logic [NF-1:0] usb_fifo_acc = '0;
    logic          usb_suspend = 1'b0;
    logic          usb_resume = 1'b0;
    logic          usb_bus_rst = 1'b0;
    logic          tmr0_ovf = 1'b0;
    logic          tmr1_ovf = 1'b0;
    logic          ext_pin = 1'b0;
    logic          ext_irq_en = 1'b0;
    logic          stack_full = 1'b0;
    logic          irq_take;
    logic [VW-1:0] irq_vec;
    logic          irq_ack = 1'b0;
    logic          wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vec_irq_ctrl #(.NUM_FIFO(NF), .VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
        .usb_fifo_acc(usb_fifo_acc), .usb_suspend(usb_suspend),
        .usb_resume(usb_resume), .usb_bus_rst(usb_bus_rst),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .ext_pin(ext_pin), .ext_irq_en(ext_irq_en),
        .stack_full(stack_full), .irq_take(irq_take), .irq_vec(irq_vec),
        .irq_ack(irq_ack), .wake(wake)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 ctrl", reg_rdata, 0);
        chk("R1 stat", stat_rdata, 0);
        chk("R1 take", irq_take, 0);
        chk("R1 wake", wake, 0);

        // R2 write sweep, offers blocked by full stack
        stack_full = 1'b1;
        for (int v = 0; v < 256; v++) begin
            wr_ctrl(8'(v));
            chk("R2 readback", reg_rdata, v & 8'h7F);
            chk("R7 no take while full", irq_take, 0);
        end
        wr_ctrl(8'h00);
        stack_full = 1'b0;
        tick();

        // R3 timers
        tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
        chk("R3 t0 flag", reg_rdata, 8'h20);
        tmr1_ovf = 1'b1; tick(); tmr1_ovf = 1'b0;
        chk("R3 t1 flag", reg_rdata, 8'h60);
        wr_ctrl(8'h00);

        // R3 R4 usb event kinds
        for (int k = 0; k < NF + 3; k++) begin
            int exp_stat;
            if (k < NF) begin
                usb_fifo_acc = NF'(1 << k);
                exp_stat = 1 << (4 + k);
            end else if (k == NF) begin
                usb_suspend = 1'b1;
                exp_stat = 1;
            end else if (k == NF + 1) begin
                usb_resume = 1'b1;
                exp_stat = 8;
            end else begin
                usb_bus_rst = 1'b1;
                exp_stat = 0;
            end
            tick();
            usb_fifo_acc = '0; usb_suspend = 1'b0; usb_resume = 1'b0; usb_bus_rst = 1'b0;
            chk("R3 usb flag", reg_rdata, 8'h10);
            chk("R4 status set", stat_rdata, exp_stat);
            tick(); tick();
            chk("R4 status holds", stat_rdata, exp_stat);
            stat_wr = 1'b1; stat_wdata = '0; tick(); stat_wr = 1'b0;
            wr_ctrl(8'h00);
            chk("R4 status cleared", stat_rdata, 0);
        end

        // R10 hardware set beats firmware clear
        tmr1_ovf = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00;
        tick();
        tmr1_ovf = 1'b0; reg_wr = 1'b0;
        chk("R10 ctrl set wins", reg_rdata, 8'h40);
        usb_suspend = 1'b1; stat_wr = 1'b1; stat_wdata = '0;
        tick();
        usb_suspend = 1'b0; stat_wr = 1'b0;
        chk("R10 status set wins", stat_rdata, 1);
        stat_wr = 1'b1; tick(); stat_wr = 1'b0;
        wr_ctrl(8'h00);

        // R5 R6 R8 R9 R11 sweep over enables and flags
        for (int en = 0; en < 8; en++) begin
            for (int fl = 0; fl < 8; fl++) begin
                int req;
                int ev;
                int fbit;
                logic [7:0] w;
                req = en & fl;
                w = 8'((fl << 4) | (en << 1) | 1);
                ev = 0; fbit = 0;
                if (req[0]) begin ev = 8'h04; fbit = 8'h10; end
                else if (req[1]) begin ev = 8'h08; fbit = 8'h20; end
                else if (req[2]) begin ev = 8'h0C; fbit = 8'h40; end
                wr_ctrl(w);
                chk("R11 wake", wake, (req != 0) ? 1 : 0);
                chk("R5 not yet", irq_take, 0);
                tick();
                chk("R5 take", irq_take, (req != 0) ? 1 : 0);
                if (req != 0) begin
                    chk("R6 vector", irq_vec, ev);
                    tick();
                    chk("R8 held", irq_take, 1);
                    chk("R8 vector held", irq_vec, ev);
                    irq_ack = 1'b1;
                    tick();
                    irq_ack = 1'b0;
                    chk("R8 take drop", irq_take, 0);
                    chk("R8 ctrl after ack", reg_rdata, int'(w) & ~1 & ~fbit);
                    tick(); tick();
                    chk("R9 no retake", irq_take, 0);
                end
                wr_ctrl(8'h00);
                tick();
            end
        end

        // R7 stack full holds the request
        stack_full = 1'b1;
        wr_ctrl(8'h25);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R7 blocked", irq_take, 0);
        end
        stack_full = 1'b0;
        tick();
        chk("R7 released", irq_take, 1);
        chk("R7 vector", irq_vec, 8'h08);
        stack_full = 1'b1;
        tick(); tick();
        chk("R8 offer kept", irq_take, 1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        stack_full = 1'b0;
        chk("R8 t0 cleared", reg_rdata, 8'h04);
        wr_ctrl(8'h00);

        // R12 external pin
        wr_ctrl(8'h01);
        ext_pin = 1'b1;
        tick();
        chk("R12 ext status", stat_rdata, 2);
        chk("R11 ext no wake", wake, 0);
        tick();
        chk("R12 ext disabled", irq_take, 0);
        ext_irq_en = 1'b1;
        tick();
        chk("R12 ext take", irq_take, 1);
        chk("R6 ext vector", irq_vec, 8'h04);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R8 ext ack", reg_rdata, 0);
        wr_ctrl(8'h01);
        tick(); tick();
        chk("R12 level no retrigger", irq_take, 0);
        ext_pin = 1'b0; tick();
        ext_pin = 1'b1; tick();
        tick();
        chk("R12 new edge", irq_take, 1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R4 ext status holds", stat_rdata, 2);

        finish_run();
    end

endmodule